// File: doc/BRIEF.md
# Snooping MSI Line Coherence Controller

This block keeps a small direct-mapped group of private cache lines coherent with the other caches on a shared snooping bus. Each line holds one data word, an address tag and one of three states: Modified, Shared or Invalid. The processor side issues reads and writes. Hits are served locally. Misses and write upgrades become bus requests, and each one completes when the memory side grants the bus and later returns the fill.

On the bus side the block receives requests from other caches. Each is either a plain read or a read-for-ownership. The block answers every such request with a shared bit, a dirty bit and a one-cycle acknowledge. It flushes its word when it owns the only up-to-date copy.

Two caches can race to write the same line. Without a guard, each can take the line from the other before its own store lands, so neither store ever completes. To prevent this, once this block's ownership request has been granted, it withholds its answer to any snoop of that same address until the local write has been stored. Snoops to every other address are still answered at once.

Top module: `coh_line_ctrl`

## Requirements
- R1: A snooped plain read (snp_cmd_i = 0) that hits a Modified line is acknowledged with shared = 1 and dirty = 1. In the same cycle the block flushes that address and its word. The line becomes Shared: a later local read hits with no bus request, and a later local write raises a bus request.
- R2: A snooped read-for-ownership (snp_cmd_i = 1) invalidates a matching line. A Modified line answers dirty = 1 and flushes its word. A Shared line answers shared = 1 and dirty = 0 with no flush. A later snooped read of that address answers shared = 0.
- R3: A local read that hits a Shared or Modified line, or a local write that hits a Modified line, raises cpu_done_o in the cycle after it is accepted. It raises no bus request, and a read returns the stored word.
- R4: A local read miss raises bus_req_o with bus_cmd_o = 0. A local write to an Invalid or Shared line raises bus_req_o with bus_cmd_o = 1. cpu_done_o stays low until fill_done_i has been seen after a grant, and rises in the cycle after that fill. A read fill leaves the line Shared holding the fill word. A write fill leaves it Modified holding the written word.
- R5: From the grant of a local ownership request until its fill, a snoop to the same address gets no acknowledge. The acknowledge comes in the cycle after cpu_done_o rises, with dirty = 1 and a flush of the newly written word. The line then follows R1 or R2.
- R6: While a miss is outstanding, snoops to other addresses are still answered one cycle after they are presented, with R1 and R2 applied to their lines.
- R7: A snoop to an address not held in a valid line is acknowledged one cycle after it is presented, with shared = 0, dirty = 0 and no flush. snp_ack_o is a single-cycle pulse.
- R8: A miss whose index holds a Modified line with a different tag flushes that line's address and word in the same cycle that bus_req_o rises.
- R9: Two controllers that write the same line at the same time, served one bus transaction at a time, both complete. The second writer ends with the line Modified holding its word, and it received the first writer's word through the first writer's flush. The first writer ends Invalid.
- R10: After reset all lines are Invalid, and cpu_done_o, bus_req_o, snp_ack_o and flush_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_req_i | input | 1 | Processor request, held until cpu_done_o |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | ADDR_W | Processor word address; low bits select the line |
| cpu_wdata_i | input | DATA_W | Write data |
| cpu_done_o | output | 1 | One-cycle completion pulse |
| cpu_rdata_o | output | DATA_W | Read data, valid with cpu_done_o |
| bus_req_o | output | 1 | Bus request pending, cleared by grant |
| bus_cmd_o | output | 1 | 0 = read, 1 = read-for-ownership |
| bus_addr_o | output | ADDR_W | Requested address |
| bus_gnt_i | input | 1 | Bus grant pulse for the pending request |
| fill_done_i | input | 1 | Fill complete pulse, after grant |
| fill_data_i | input | DATA_W | Fill word |
| snp_req_i | input | 1 | Snooped request present, held until snp_ack_o |
| snp_cmd_i | input | 1 | 0 = read, 1 = read-for-ownership |
| snp_addr_i | input | ADDR_W | Snooped address |
| snp_ack_o | output | 1 | Snoop response valid pulse |
| snp_shared_o | output | 1 | Copy held, valid with snp_ack_o |
| snp_dirty_o | output | 1 | Copy is Modified, valid with snp_ack_o |
| flush_o | output | 1 | Flush pulse |
| flush_addr_o | output | ADDR_W | Flushed address |
| flush_data_o | output | DATA_W | Flushed word |

## Verification
A line in the wrong state shows up on the snoop side: the very next snoop of that address returns the wrong shared or dirty bit, one cycle after it is presented. A lost or spurious flush is visible in that same cycle. A stale or wrong word appears either on the flush port or on the next local read hit. A broken protection window shows up in one of two ways. An early acknowledge arrives before the local write completes. Or no acknowledge arrives at all, in which case the racing pair never finishes both stores and the bench's wait loops time out.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {
    LS_I = 2'd0,
    LS_S = 2'd1,
    LS_M = 2'd2
  } line_st_e;

  localparam logic CMD_RD  = 1'b0;
  localparam logic CMD_RDX = 1'b1;
endpackage

// File: rtl/coh_snoop_resp.sv
module coh_snoop_resp
  import coh_pkg::*;
#(
  parameter int TAG_W = 6
) (
  input  line_st_e           st_i,
  input  logic [TAG_W-1:0]   line_tag_i,
  input  logic [TAG_W-1:0]   snp_tag_i,
  input  logic               snp_cmd_i,
  output logic               hit_o,
  output logic               shared_o,
  output logic               dirty_o,
  output logic               flush_o,
  output line_st_e           next_st_o
);
  always_comb begin
    hit_o     = (st_i != LS_I) && (line_tag_i == snp_tag_i);
    shared_o  = hit_o;
    dirty_o   = hit_o && (st_i == LS_M);
    flush_o   = dirty_o;
    next_st_o = st_i;
    if (hit_o) next_st_o = (snp_cmd_i == CMD_RDX) ? LS_I : LS_S;
  end
endmodule

// File: rtl/coh_miss_tracker.sv
module coh_miss_tracker
  import coh_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              start_we_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              bus_gnt_i,
  input  logic              fill_done_i,
  output logic              busy_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              guarded_o,
  output logic              bus_req_o,
  output logic              bus_cmd_o,
  output logic              retire_o
);
  logic              pend_q, we_q, gnt_seen_q, req_q;
  logic [ADDR_W-1:0] addr_q;

  assign retire_o  = pend_q && gnt_seen_q && fill_done_i;
  assign busy_o    = pend_q;
  assign we_o      = we_q;
  assign addr_o    = addr_q;
  assign guarded_o = pend_q && we_q && gnt_seen_q;
  assign bus_req_o = req_q;
  assign bus_cmd_o = we_q ? CMD_RDX : CMD_RD;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= 1'b0;
      we_q       <= 1'b0;
      gnt_seen_q <= 1'b0;
      req_q      <= 1'b0;
      addr_q     <= '0;
    end else if (start_i) begin
      pend_q     <= 1'b1;
      we_q       <= start_we_i;
      addr_q     <= start_addr_i;
      req_q      <= 1'b1;
      gnt_seen_q <= 1'b0;
    end else begin
      if (req_q && bus_gnt_i) begin
        req_q      <= 1'b0;
        gnt_seen_q <= 1'b1;
      end
      if (retire_o) begin
        pend_q     <= 1'b0;
        gnt_seen_q <= 1'b0;
      end
    end
  end

  assert_req_has_pend_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> busy_o);
  assert_start_when_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !pend_q);
  assert_retire_drops_guard_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_o |=> !guarded_o);
endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl
  import coh_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int NUM_LINES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_done_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              bus_req_o,
  output logic              bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  input  logic              bus_gnt_i,
  input  logic              fill_done_i,
  input  logic [DATA_W-1:0] fill_data_i,
  input  logic              snp_req_i,
  input  logic              snp_cmd_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  output logic              snp_ack_o,
  output logic              snp_shared_o,
  output logic              snp_dirty_o,
  output logic              flush_o,
  output logic [ADDR_W-1:0] flush_addr_o,
  output logic [DATA_W-1:0] flush_data_o
);
  localparam int IDX_W = $clog2(NUM_LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  line_st_e          st_vec   [NUM_LINES];
  logic [TAG_W-1:0]  tag_vec  [NUM_LINES];
  logic [DATA_W-1:0] data_vec [NUM_LINES];

  logic [IDX_W-1:0] cidx, sidx, pidx;
  logic [TAG_W-1:0] ctag, stag, ptag;
  assign cidx = cpu_addr_i[IDX_W-1:0];
  assign ctag = cpu_addr_i[ADDR_W-1:IDX_W];
  assign sidx = snp_addr_i[IDX_W-1:0];
  assign stag = snp_addr_i[ADDR_W-1:IDX_W];

  // miss tracking
  logic              busy, pend_we, guarded, retire, miss_start;
  logic [ADDR_W-1:0] pend_addr;
  assign pidx = pend_addr[IDX_W-1:0];
  assign ptag = pend_addr[ADDR_W-1:IDX_W];

  coh_miss_tracker #(.ADDR_W(ADDR_W)) u_miss (
    .clk_i, .rst_ni,
    .start_i      (miss_start),
    .start_we_i   (cpu_we_i),
    .start_addr_i (cpu_addr_i),
    .bus_gnt_i, .fill_done_i,
    .busy_o       (busy),
    .we_o         (pend_we),
    .addr_o       (pend_addr),
    .guarded_o    (guarded),
    .bus_req_o, .bus_cmd_o,
    .retire_o     (retire)
  );
  assign bus_addr_o = pend_addr;

  // snoop side
  logic     s_hit, s_shared, s_dirty, s_flush, hold, snp_take, snp_wr;
  line_st_e s_next;
  coh_snoop_resp #(.TAG_W(TAG_W)) u_resp (
    .st_i       (st_vec[sidx]),
    .line_tag_i (tag_vec[sidx]),
    .snp_tag_i  (stag),
    .snp_cmd_i,
    .hit_o      (s_hit),
    .shared_o   (s_shared),
    .dirty_o    (s_dirty),
    .flush_o    (s_flush),
    .next_st_o  (s_next)
  );

  logic ack_q, done_q;
  // write held by a granted ownership request blocks snoops to its address
  assign hold     = guarded && (snp_addr_i == pend_addr);
  assign snp_take = snp_req_i && !ack_q && !hold;
  assign snp_wr   = snp_take && s_hit;

  // processor side
  line_st_e cst;
  logic     cpu_hit, cpu_take, local_done, victim_flush;
  assign cst        = st_vec[cidx];
  assign cpu_hit    = (cst != LS_I) && (tag_vec[cidx] == ctag);
  assign cpu_take   = cpu_req_i && !done_q && !busy && !snp_take;
  assign local_done = cpu_take && cpu_hit && (!cpu_we_i || cst == LS_M);
  assign miss_start = cpu_take && !local_done;
  assign victim_flush = miss_start && !cpu_hit && (cst == LS_M);

  // line write port from processor / fill
  logic              cw_en, cw_data_en;
  logic [IDX_W-1:0]  cw_idx;
  line_st_e          cw_st;
  logic [TAG_W-1:0]  cw_tag;
  logic [DATA_W-1:0] cw_data;

  always_comb begin
    cw_en      = 1'b0;
    cw_data_en = 1'b0;
    cw_idx     = cidx;
    cw_st      = LS_I;
    cw_tag     = ctag;
    cw_data    = cpu_wdata_i;
    if (retire) begin
      cw_en      = 1'b1;
      cw_data_en = 1'b1;
      cw_idx     = pidx;
      cw_tag     = ptag;
      cw_st      = pend_we ? LS_M : LS_S;
      cw_data    = pend_we ? cpu_wdata_i : fill_data_i;
    end else if (local_done && cpu_we_i) begin
      cw_en      = 1'b1;
      cw_data_en = 1'b1;
      cw_st      = LS_M;
    end else if (miss_start && !cpu_hit) begin
      cw_en = 1'b1;  // drop old occupant; its flush is raised below
      cw_st = LS_I;
    end
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    line_st_e          st_q;
    logic [TAG_W-1:0]  tag_q;
    logic [DATA_W-1:0] data_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q   <= LS_I;
        tag_q  <= '0;
        data_q <= '0;
      end else begin
        if (snp_wr && sidx == IDX_W'(g)) st_q <= s_next;
        if (cw_en && cw_idx == IDX_W'(g)) begin
          st_q <= cw_st;
          if (cw_data_en) begin
            tag_q  <= cw_tag;
            data_q <= cw_data;
          end
        end
      end
    end
    assign st_vec[g]   = st_q;
    assign tag_vec[g]  = tag_q;
    assign data_vec[g] = data_q;
  end

  // response and output registers
  logic              shd_q, drt_q, flush_q;
  logic [DATA_W-1:0] rdata_q, fdata_q;
  logic [ADDR_W-1:0] faddr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q  <= 1'b0;
      rdata_q <= '0;
      ack_q   <= 1'b0;
      shd_q   <= 1'b0;
      drt_q   <= 1'b0;
      flush_q <= 1'b0;
      faddr_q <= '0;
      fdata_q <= '0;
    end else begin
      done_q  <= local_done || retire;
      if (local_done) rdata_q <= cpu_we_i ? cpu_wdata_i : data_vec[cidx];
      else if (retire) rdata_q <= pend_we ? cpu_wdata_i : fill_data_i;
      ack_q   <= snp_take;
      shd_q   <= snp_take && s_shared;
      drt_q   <= snp_take && s_dirty;
      flush_q <= (snp_take && s_flush) || victim_flush;
      if (snp_take && s_flush) begin
        faddr_q <= snp_addr_i;
        fdata_q <= data_vec[sidx];
      end else if (victim_flush) begin
        faddr_q <= {tag_vec[cidx], cidx};
        fdata_q <= data_vec[cidx];
      end
    end
  end

  assign cpu_done_o   = done_q;
  assign cpu_rdata_o  = rdata_q;
  assign snp_ack_o    = ack_q;
  assign snp_shared_o = shd_q;
  assign snp_dirty_o  = drt_q;
  assign flush_o      = flush_q;
  assign flush_addr_o = faddr_q;
  assign flush_data_o = fdata_q;

  assert_dirty_flushes_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_ack_o && snp_dirty_o) |-> (flush_o && flush_addr_o == $past(snp_addr_i)));
  assert_hit_no_bus_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_take && cpu_we_i && cpu_hit && cst == LS_M) |=> !bus_req_o);
  assert_fill_completes_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire |=> cpu_done_o);
  assert_hold_same_line_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_req_i && guarded && snp_addr_i == pend_addr) |=> !snp_ack_o);
  assert_one_writer_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_wr && cw_en) |-> (sidx != cw_idx));
  assert_ack_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_ack_o |=> !snp_ack_o);
endmodule

// File: tb/coh_line_ctrl_bench.sv
module coh_line_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          cpu_req [2], cpu_we [2], cpu_done [2];
  logic [AW-1:0] cpu_addr [2];
  logic [DW-1:0] cpu_wdata [2], cpu_rdata [2];
  logic          bus_req [2], bus_cmd [2], gnt [2], fill [2];
  logic [AW-1:0] bus_addr [2];
  logic [DW-1:0] fill_data [2];
  logic          snp_req [2], snp_cmd [2], snp_ack [2], snp_sh [2], snp_dr [2];
  logic [AW-1:0] snp_addr [2];
  logic          flush [2];
  logic [AW-1:0] flush_addr [2];
  logic [DW-1:0] flush_data [2];

  coh_line_ctrl u_coh_line_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(cpu_req[0]), .cpu_we_i(cpu_we[0]), .cpu_addr_i(cpu_addr[0]),
    .cpu_wdata_i(cpu_wdata[0]), .cpu_done_o(cpu_done[0]), .cpu_rdata_o(cpu_rdata[0]),
    .bus_req_o(bus_req[0]), .bus_cmd_o(bus_cmd[0]), .bus_addr_o(bus_addr[0]),
    .bus_gnt_i(gnt[0]), .fill_done_i(fill[0]), .fill_data_i(fill_data[0]),
    .snp_req_i(snp_req[0]), .snp_cmd_i(snp_cmd[0]), .snp_addr_i(snp_addr[0]),
    .snp_ack_o(snp_ack[0]), .snp_shared_o(snp_sh[0]), .snp_dirty_o(snp_dr[0]),
    .flush_o(flush[0]), .flush_addr_o(flush_addr[0]), .flush_data_o(flush_data[0])
  );

  coh_line_ctrl u_peer (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(cpu_req[1]), .cpu_we_i(cpu_we[1]), .cpu_addr_i(cpu_addr[1]),
    .cpu_wdata_i(cpu_wdata[1]), .cpu_done_o(cpu_done[1]), .cpu_rdata_o(cpu_rdata[1]),
    .bus_req_o(bus_req[1]), .bus_cmd_o(bus_cmd[1]), .bus_addr_o(bus_addr[1]),
    .bus_gnt_i(gnt[1]), .fill_done_i(fill[1]), .fill_data_i(fill_data[1]),
    .snp_req_i(snp_req[1]), .snp_cmd_i(snp_cmd[1]), .snp_addr_i(snp_addr[1]),
    .snp_ack_o(snp_ack[1]), .snp_shared_o(snp_sh[1]), .snp_dirty_o(snp_dr[1]),
    .flush_o(flush[1]), .flush_addr_o(flush_addr[1]), .flush_data_o(flush_data[1])
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [DW-1:0] mem_word;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic cpu_start(int i, logic we, logic [AW-1:0] a, logic [DW-1:0] d);
    cpu_req[i] = 1'b1; cpu_we[i] = we; cpu_addr[i] = a; cpu_wdata[i] = d;
  endtask

  task automatic wait_done(int i, output int lat);
    lat = 0;
    do begin tick(); lat++; end while (!cpu_done[i] && lat < 60);
  endtask

  task automatic wait_bus(int i, output int lat);
    lat = 0;
    do begin tick(); lat++; end while (!bus_req[i] && lat < 60);
  endtask

  task automatic grant(int i);
    gnt[i] = 1'b1; tick(); gnt[i] = 1'b0;
  endtask

  task automatic fill_line(int i, logic [DW-1:0] d);
    fill[i] = 1'b1; fill_data[i] = d; tick(); fill[i] = 1'b0;
  endtask

  task automatic snoop(int i, logic cmd, logic [AW-1:0] a, output logic sh, output logic dr,
                       output logic fl, output logic [DW-1:0] fd, output int lat);
    snp_req[i] = 1'b1; snp_cmd[i] = cmd; snp_addr[i] = a;
    lat = 0;
    do begin tick(); lat++; end while (!snp_ack[i] && lat < 60);
    sh = snp_sh[i]; dr = snp_dr[i]; fl = flush[i]; fd = flush_data[i];
    snp_req[i] = 1'b0;
    tick();
  endtask

  task automatic cpu_hit_op(string tag, logic we, logic [AW-1:0] a, logic [DW-1:0] d,
                            logic [DW-1:0] exp_rd);
    int lat;
    cpu_start(0, we, a, d);
    wait_done(0, lat);
    chk({tag, " hit latency"}, lat, 1);
    chk({tag, " hit no bus request"}, bus_req[0], 0);
    if (!we) chk({tag, " hit read data"}, cpu_rdata[0], exp_rd);
    cpu_req[0] = 1'b0;
    tick();
  endtask

  task automatic cpu_miss(string tag, logic we, logic [AW-1:0] a, logic [DW-1:0] d,
                          logic [DW-1:0] fd);
    int lat;
    cpu_start(0, we, a, d);
    wait_bus(0, lat);
    chk({tag, " bus request cmd"}, {bus_req[0], bus_cmd[0]}, {1'b1, we});
    chk({tag, " bus address"}, bus_addr[0], a);
    grant(0);
    chk({tag, " no done before fill"}, cpu_done[0], 0);
    fill_line(0, fd);
    chk({tag, " done after fill"}, cpu_done[0], 1);
    if (!we) chk({tag, " fill read data"}, cpu_rdata[0], fd);
    cpu_req[0] = 1'b0;
    tick();
  endtask

  // R10
  task automatic t_reset();
    logic sh, dr, fl; logic [DW-1:0] fd; int lat;
    chk("R10 outputs idle", {cpu_done[0], bus_req[0], snp_ack[0], flush[0]}, 0);
    snoop(0, 1'b0, 8'h10, sh, dr, fl, fd, lat);
    chk("R10 line invalid after reset", {sh, dr, fl}, 0);
  endtask

  // R4 / R3
  task automatic t_read_paths();
    cpu_miss("R4 read miss", 1'b0, 8'h21, 16'h0, 16'hbeef);
    cpu_hit_op("R3 read hit S", 1'b0, 8'h21, 16'h0, 16'hbeef);
    cpu_miss("R4 write upgrade from S", 1'b1, 8'h21, 16'h1111, 16'h0);
    cpu_hit_op("R3 write hit M", 1'b1, 8'h21, 16'h2222, 16'h0);
    cpu_hit_op("R3 read hit M", 1'b0, 8'h21, 16'h0, 16'h2222);
  endtask

  // R1
  task automatic t_snoop_read_m();
    logic sh, dr, fl; logic [DW-1:0] fd; int lat;
    snp_req[0] = 1'b1; snp_cmd[0] = 1'b0; snp_addr[0] = 8'h21;
    tick();
    chk("R1 ack after one cycle", snp_ack[0], 1);
    chk("R1 shared/dirty/flush", {snp_sh[0], snp_dr[0], flush[0]}, 3'b111);
    chk("R1 flush addr", flush_addr[0], 8'h21);
    chk("R1 flush data", flush_data[0], 16'h2222);
    snp_req[0] = 1'b0;
    tick();
    chk("R7 ack single pulse", snp_ack[0], 0);
    cpu_hit_op("R1 read hits after downgrade", 1'b0, 8'h21, 16'h0, 16'h2222);
    cpu_miss("R1 write on S needs bus", 1'b1, 8'h21, 16'h2323, 16'h0);
    snoop(0, 1'b0, 8'h21, sh, dr, fl, fd, lat);
    chk("R4 write fill leaves M", {sh, dr, fl}, 3'b111);
    chk("R4 written word kept", fd, 16'h2323);
    cpu_miss("R1 write again from S", 1'b1, 8'h21, 16'h2424, 16'h0);
  endtask

  // R2
  task automatic t_snoop_rdx();
    logic sh, dr, fl; logic [DW-1:0] fd; int lat;
    snoop(0, 1'b1, 8'h21, sh, dr, fl, fd, lat);
    chk("R2 rdx on M response", {sh, dr, fl}, 3'b111);
    chk("R2 rdx on M flush data", fd, 16'h2424);
    snoop(0, 1'b0, 8'h21, sh, dr, fl, fd, lat);
    chk("R2 M line invalidated", {sh, dr, fl}, 0);
    cpu_miss("R2 S setup", 1'b0, 8'h32, 16'h0, 16'h3232);
    snoop(0, 1'b1, 8'h32, sh, dr, fl, fd, lat);
    chk("R2 rdx on S response", {sh, dr, fl}, 3'b100);
    snoop(0, 1'b0, 8'h32, sh, dr, fl, fd, lat);
    chk("R2 S line invalidated", {sh, dr, fl}, 0);
  endtask

  // R7
  task automatic t_absent();
    logic sh, dr, fl; logic [DW-1:0] fd; int lat;
    snoop(0, 1'b0, 8'h45, sh, dr, fl, fd, lat);
    chk("R7 absent latency", lat, 1);
    chk("R7 absent response", {sh, dr, fl}, 0);
  endtask

  // R8
  task automatic t_victim();
    int lat;
    cpu_miss("R8 setup write miss", 1'b1, 8'h13, 16'h3333, 16'h0);
    cpu_start(0, 1'b0, 8'h53, 16'h0);
    wait_bus(0, lat);
    chk("R8 flush with bus request", flush[0], 1);
    chk("R8 victim addr", flush_addr[0], 8'h13);
    chk("R8 victim data", flush_data[0], 16'h3333);
    chk("R4 read miss cmd", bus_cmd[0], 0);
    grant(0);
    fill_line(0, 16'h5555);
    chk("R8 new line read", {cpu_done[0], cpu_rdata[0]}, {1'b1, 16'h5555});
    cpu_req[0] = 1'b0;
    tick();
  endtask

  // R5
  task automatic t_protect();
    logic sh, dr, fl; logic [DW-1:0] fd; int lat;
    cpu_start(0, 1'b1, 8'h61, 16'h6161);
    wait_bus(0, lat);
    grant(0);
    snp_req[0] = 1'b1; snp_cmd[0] = 1'b1; snp_addr[0] = 8'h61;
    for (int k = 0; k < 4; k++) begin
      tick();
      chk("R5 no ack while write pending", snp_ack[0], 0);
    end
    fill_line(0, 16'h0);
    chk("R5 local write done first", {cpu_done[0], snp_ack[0]}, 2'b10);
    cpu_req[0] = 1'b0;
    tick();
    chk("R5 deferred ack next cycle", snp_ack[0], 1);
    chk("R5 deferred response dirty", {snp_sh[0], snp_dr[0], flush[0]}, 3'b111);
    chk("R5 flush carries written word", flush_data[0], 16'h6161);
    snp_req[0] = 1'b0;
    tick();
    snoop(0, 1'b0, 8'h61, sh, dr, fl, fd, lat);
    chk("R5 line given up after write", {sh, dr, fl}, 0);
  endtask

  // R6
  task automatic t_other_line();
    logic sh, dr, fl; logic [DW-1:0] fd; int lat;
    cpu_miss("R6 S setup", 1'b0, 8'h32, 16'h0, 16'h3232);
    cpu_start(0, 1'b1, 8'h74, 16'h7474);
    wait_bus(0, lat);
    grant(0);
    snoop(0, 1'b1, 8'h32, sh, dr, fl, fd, lat);
    chk("R6 other line latency", lat, 1);
    chk("R6 other line response", {sh, dr, fl}, 3'b100);
    chk("R6 miss still pending", cpu_done[0], 0);
    fill_line(0, 16'h0);
    chk("R6 pending write completes", cpu_done[0], 1);
    cpu_req[0] = 1'b0;
    tick();
    snoop(0, 1'b0, 8'h32, sh, dr, fl, fd, lat);
    chk("R6 other line invalidated", {sh, dr, fl}, 0);
  endtask

  task automatic bus_txn(string tag, int w, output logic sh, output logic dr);
    logic fl; logic [DW-1:0] fd; int lat;
    logic cmd; logic [AW-1:0] a;
    int o = 1 - w;
    chk({tag, " request raised"}, bus_req[w], 1);
    cmd = bus_cmd[w]; a = bus_addr[w];
    grant(w);
    snoop(o, cmd, a, sh, dr, fl, fd, lat);
    if (fl) mem_word = fd;
    fill_line(w, mem_word);
    chk({tag, " requester done"}, cpu_done[w], 1);
    cpu_req[w] = 1'b0;
    tick();
  endtask

  // R9
  task automatic t_compete();
    logic sh, dr, fl; logic [DW-1:0] fd; int lat;
    mem_word = 16'h0500;
    cpu_start(0, 1'b0, 8'h40, 16'h0); wait_bus(0, lat);
    bus_txn("R9 read A", 0, sh, dr);
    cpu_start(1, 1'b0, 8'h40, 16'h0); wait_bus(1, lat);
    bus_txn("R9 read B", 1, sh, dr);
    chk("R9 A shared copy seen", {sh, dr}, 2'b10);
    chk("R9 B read word", cpu_rdata[1], 16'h0500);
    cpu_start(0, 1'b1, 8'h40, 16'haaaa);
    cpu_start(1, 1'b1, 8'h40, 16'hbbbb);
    tick();
    chk("R9 both request", {bus_req[0], bus_req[1], bus_cmd[0], bus_cmd[1]}, 4'hf);
    bus_txn("R9 write A", 0, sh, dr);
    chk("R9 B yields ungranted S", {sh, dr}, 2'b10);
    bus_txn("R9 write B", 1, sh, dr);
    chk("R9 A hands over dirty", {sh, dr}, 2'b11);
    chk("R9 A flushed its word", mem_word, 16'haaaa);
    snoop(1, 1'b0, 8'h40, sh, dr, fl, fd, lat);
    chk("R9 B ends M", {sh, dr, fl}, 3'b111);
    chk("R9 B holds its word", fd, 16'hbbbb);
    snoop(0, 1'b0, 8'h40, sh, dr, fl, fd, lat);
    chk("R9 A ends I", {sh, dr, fl}, 0);
  endtask

  initial begin
    for (int i = 0; i < 2; i++) begin
      cpu_req[i] = 0; cpu_we[i] = 0; cpu_addr[i] = '0; cpu_wdata[i] = '0;
      gnt[i] = 0; fill[i] = 0; fill_data[i] = '0;
      snp_req[i] = 0; snp_cmd[i] = 0; snp_addr[i] = '0;
    end
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_read_paths();
    t_snoop_read_m();
    t_snoop_rdx();
    t_absent();
    t_victim();
    t_protect();
    t_other_line();
    t_compete();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule